// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Page Write Buffer

This block is a byte-wide serial memory that answers a host on a two-wire bus (SCL clock, SDA open-drain data). It runs entirely on a fast system clock: both bus lines pass through synchronizers, and all bus timing is recovered from edges detected on the synchronized lines. The slave never drives SDA high. It only asserts an output enable that pulls the line low, and it changes that enable only while SCL is low.

A host addresses the slave with a control byte, then sends one word address and any number of data bytes. The data bytes collect in a page buffer. On the closing Stop, a timed programming cycle copies them into the internal array. While that cycle runs, the slave stays silent on the bus. A host reads with a random read (address write, repeated Start, read control byte), with a current-address read, or by acknowledging each byte to stream sequential data.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: While reset is asserted, and afterwards until the slave is addressed, `sda_oe` is 0.
- R2: A falling SDA while SCL is high (Start) begins reception of a control byte from any state. A rising SDA while SCL is high (Stop) returns the slave to idle. Both leave `sda_oe` at 0.
- R3: The control byte is received MSB first. Bits 7:4 must be 1010, bits 3:1 must equal `ADDR_SEL`, and bit 0 selects the direction (1 = read). On a mismatch the slave gives no acknowledge and ignores every later bit until the next Start.
- R4: After each byte it receives in an addressed transfer (control, word address, write data), the slave holds SDA low for the whole high phase of the ninth SCL pulse.
- R5: Write data byte k (k counted from 0) goes to the address whose upper four bits come from the word address and whose low four bits are the word address's low four bits plus k, modulo 16. When more than 16 bytes arrive, later bytes replace earlier ones at the same position.
- R6: A Stop that ends a write carrying at least one data byte starts a programming cycle of exactly `PROG_CYCLES` system clocks. A Stop that follows only a word address starts none.
- R7: While a programming cycle runs, no byte is acknowledged, including a matching control byte.
- R8: Read data is driven MSB first. After each byte sent, the address pointer advances by one, wrapping from 255 to 0.
- R9: A current-address read returns the byte at the pointer. The word address loads the pointer, each read byte adds one across all eight bits, and each write byte adds one to the low four bits only.
- R10: When the host leaves its acknowledge bit high after a read byte, the slave releases SDA and drives nothing until the next Start.
- R11: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (includes the slave's own pull-down) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
On every cycle, the checker confirms that the data enable moves only while the bus clock is low, that Start, Stop and reset leave the line released, and that the slave stays silent during programming. It also checks that array writes happen only inside the programming window and that this window lasts exactly the configured number of clocks. What the array holds after a page write overflows or wraps, where the pointer lands for current-address and wrapping sequential reads, and whether acknowledges are present or absent can only be shown by the bench's bus transactions, which compare the bytes read back against values the bench predicts.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_IGNORE
  } xfer_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
  parameter int AW          = 8,
  parameter int PW          = 4,
  parameter int PROG_CYCLES = 1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_off,
  input  logic [7:0]    wr_data,
  input  logic          commit,
  input  logic [AW-PW-1:0] commit_page,
  output logic          busy,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata
);
  localparam int PAGE = 2 ** PW;
  localparam int CW   = $clog2(PROG_CYCLES + 1);

  logic [7:0]      slot [PAGE];
  logic [PAGE-1:0] filled;
  logic [CW-1:0]   tmr;
  logic [AW-PW-1:0] page_q;
  logic [PW-1:0]   idx;

  assign idx = tmr[PW-1:0];

  always_ff @(posedge clk) begin
    if (wr_en) slot[wr_off] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      filled    <= '0;
      busy      <= 1'b0;
      tmr       <= '0;
      page_q    <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (busy) begin
        tmr <= tmr + 1'b1;
        if (tmr < CW'(PAGE)) begin
          mem_we    <= filled[idx];
          mem_addr  <= {page_q, idx};
          mem_wdata <= slot[idx];
        end
        if (tmr == CW'(PROG_CYCLES - 1)) begin
          busy   <= 1'b0;
          filled <= '0;
        end
      end else if (commit) begin
        busy   <= 1'b1;
        tmr    <= '0;
        page_q <= commit_page;
      end
      if (clr) filled <= '0;
      else if (wr_en) filled[wr_off] <= 1'b1;
    end
  end
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [2**AW];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
  import eeprom_pkg::*;
#(
  parameter logic [2:0] ADDR_SEL    = 3'b000,
  parameter int         MEM_DEPTH   = 256,
  parameter int         PAGE_BYTES  = 16,
  parameter int         PROG_CYCLES = 1000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int         AW       = $clog2(MEM_DEPTH);
  localparam int         PW       = $clog2(PAGE_BYTES);
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  xfer_state_t   state;
  logic [3:0]    bit_cnt;
  logic          ack_phase, host_ack, rnw, wrote;
  logic [7:0]    rx_sh, tx_sh, rd_data;
  logic [AW-1:0] ptr;
  logic          byte_done, ctrl_hit, buf_clr, buf_we, commit, prog_busy;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [7:0]    mem_wdata;

  assign byte_done = scl_fall && !ack_phase && bit_cnt == 4'd8;
  assign ctrl_hit  = rx_sh[7:4] == DEV_TYPE && rx_sh[3:1] == ADDR_SEL && !prog_busy;
  assign buf_clr   = byte_done && state == ST_ADDR;
  assign buf_we    = byte_done && state == ST_WDATA;
  assign commit    = stop_det && state == ST_WDATA && wrote;

  eeprom_page_buf #(.AW(AW), .PW(PW), .PROG_CYCLES(PROG_CYCLES)) u_page (
    .clk(clk), .rst(rst), .clr(buf_clr), .wr_en(buf_we),
    .wr_off(ptr[PW-1:0]), .wr_data(rx_sh), .commit(commit),
    .commit_page(ptr[AW-1:PW]), .busy(prog_busy),
    .mem_we(mem_we), .mem_addr(mem_waddr), .mem_wdata(mem_wdata)
  );

  eeprom_array #(.AW(AW)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(ptr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      ack_phase <= 1'b0;
      host_ack  <= 1'b0;
      rnw       <= 1'b0;
      wrote     <= 1'b0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      ptr       <= '0;
      sda_oe    <= 1'b0;
    end else if (start_det) begin
      state     <= ST_CTRL;
      bit_cnt   <= '0;
      ack_phase <= 1'b0;
      wrote     <= 1'b0;
      sda_oe    <= 1'b0;
    end else if (stop_det) begin
      state     <= ST_IDLE;
      ack_phase <= 1'b0;
      sda_oe    <= 1'b0;
    end else if (scl_rise) begin
      if (ack_phase) host_ack <= ~sda_s;
      else if ((state == ST_CTRL || state == ST_ADDR || state == ST_WDATA) && bit_cnt < 4'd8) begin
        rx_sh   <= {rx_sh[6:0], sda_s};
        bit_cnt <= bit_cnt + 1'b1;
      end
    end else if (scl_fall) begin
      if (!ack_phase) begin
        case (state)
          ST_CTRL: if (bit_cnt == 4'd8) begin
            if (ctrl_hit) begin
              sda_oe    <= 1'b1;
              ack_phase <= 1'b1;
              rnw       <= rx_sh[0];
            end else begin
              state <= ST_IGNORE;
            end
          end
          ST_ADDR: if (bit_cnt == 4'd8) begin
            sda_oe    <= 1'b1;
            ack_phase <= 1'b1;
            ptr       <= rx_sh[AW-1:0];
          end
          ST_WDATA: if (bit_cnt == 4'd8) begin
            sda_oe    <= 1'b1;
            ack_phase <= 1'b1;
            wrote     <= 1'b1;
            ptr       <= {ptr[AW-1:PW], ptr[PW-1:0] + 1'b1};
          end
          ST_RDATA: begin
            if (bit_cnt == 4'd7) begin
              sda_oe    <= 1'b0;
              ack_phase <= 1'b1;
              ptr       <= ptr + 1'b1;
            end else begin
              sda_oe  <= ~tx_sh[3'd6 - bit_cnt[2:0]];
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end else begin
        ack_phase <= 1'b0;
        bit_cnt   <= '0;
        case (state)
          ST_CTRL: begin
            if (rnw) begin
              state  <= ST_RDATA;
              tx_sh  <= rd_data;
              sda_oe <= ~rd_data[7];
            end else begin
              state  <= ST_ADDR;
              sda_oe <= 1'b0;
            end
          end
          ST_ADDR: begin
            state  <= ST_WDATA;
            sda_oe <= 1'b0;
          end
          ST_RDATA: begin
            if (host_ack) begin
              tx_sh  <= rd_data;
              sda_oe <= ~rd_data[7];
            end else begin
              state  <= ST_IGNORE;
              sda_oe <= 1'b0;
            end
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/eeprom_i2c_checker.sv
module eeprom_i2c_checker #(
  parameter int PROG_CYCLES = 1000
) (
  input logic clk,
  input logic rst,
  input logic scl_i,
  input logic sda_oe,
  input logic start_det,
  input logic stop_det,
  input logic prog_busy,
  input logic mem_we
);
  int unsigned busy_len;

  always_ff @(posedge clk) begin
    if (rst) busy_len <= 0;
    else if (prog_busy) busy_len <= busy_len + 1;
    else busy_len <= 0;
  end

  p_reset_release_r1: assert property (@(posedge clk) rst |=> !sda_oe);

  p_cond_release_r2: assert property (@(posedge clk) disable iff (rst)
    (start_det || stop_det) |=> !sda_oe);

  p_prog_length_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(prog_busy) |-> busy_len == PROG_CYCLES);

  p_write_in_window_r6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> prog_busy);

  p_silent_busy_r7: assert property (@(posedge clk) disable iff (rst)
    prog_busy |-> !sda_oe);

  p_change_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
    $changed(sda_oe) |-> !scl_i);
endmodule

bind eeprom_i2c_slave eeprom_i2c_checker #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
  .start_det(start_det), .stop_det(stop_det),
  .prog_busy(prog_busy), .mem_we(mem_we)
);

// File: tb/eeprom_i2c_slave_bench.sv
module eeprom_i2c_slave_bench;
  localparam int         Q     = 10;
  localparam int         PROG  = 1000;
  localparam logic [7:0] CTL_W = 8'hA0;
  localparam logic [7:0] CTL_R = 8'hA1;
  localparam int         NVEC  = 6;
  localparam logic [15:0] VEC [NVEC] = '{16'h005A, 16'h10C3, 16'h113E,
                                          16'h7F81, 16'h8007, 16'hFFAB};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_h = 1'b1;
  logic sda_oe;
  logic sda_line;
  int   errors = 0;
  int   checks = 0;
  int   r11_viol = 0;
  logic prev_oe = 1'b0;

  assign sda_line = sda_h & ~sda_oe;
  always #2 clk = ~clk;

  eeprom_i2c_slave #(.PROG_CYCLES(PROG)) u_eeprom_i2c_slave (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  always @(posedge clk) begin
    #1;
    if (!rst && scl && sda_oe !== prev_oe) r11_viol++;
    prev_oe = sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; wq(); scl = 1'b1; wq(); sda_h = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; wq(); scl = 1'b1; wq(); sda_h = 1'b1; wq();
  endtask

  task automatic tx_byte(input logic [7:0] b, output logic ack);
    logic a0;
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; wq(); scl = 1'b1; wq(); scl = 1'b0;
    end
    sda_h = 1'b1; wq(); scl = 1'b1;
    @(negedge clk); a0 = ~sda_line;
    repeat (Q - 2) @(negedge clk);
    ack = a0 & ~sda_line;
    @(negedge clk); scl = 1'b0;
  endtask

  task automatic rx_byte(input logic give_ack, output logic [7:0] d);
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl = 1'b1;
      repeat (Q / 2) @(negedge clk); d[i] = sda_line;
      repeat (Q - Q / 2) @(negedge clk); scl = 1'b0;
    end
    sda_h = ~give_ack; wq(); scl = 1'b1; wq(); scl = 1'b0; sda_h = 1'b1;
  endtask

  task automatic write_seq(input logic [7:0] addr, input int n, input logic [7:0] d0,
                           output int nacks);
    logic a;
    nacks = 0;
    bus_start();
    tx_byte(CTL_W, a); if (!a) nacks++;
    tx_byte(addr, a);  if (!a) nacks++;
    for (int k = 0; k < n; k++) begin
      tx_byte(d0 + 8'(k), a); if (!a) nacks++;
    end
    bus_stop();
  endtask

  task automatic set_addr_rd(input logic [7:0] addr, output int nacks);
    logic a;
    nacks = 0;
    bus_start();
    tx_byte(CTL_W, a); if (!a) nacks++;
    tx_byte(addr, a);  if (!a) nacks++;
    bus_start();
    tx_byte(CTL_R, a); if (!a) nacks++;
  endtask

  task automatic wait_prog();
    repeat (PROG + 100) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int nk;
    logic a;
    logic [7:0] rd;
    logic [7:0] rd2;
    int held;

    repeat (10) @(negedge clk);
    chk("R1 oe during reset", 32'(sda_oe), 0);
    rst = 1'b0;
    repeat (50) @(negedge clk);
    chk("R1 oe idle after reset", 32'(sda_oe), 0);

    // Vector table: single-byte write then random read (R2 repeated Start, R4 acks, R8 data)
    for (int v = 0; v < NVEC; v++) begin
      write_seq(VEC[v][15:8], 1, VEC[v][7:0], nk);
      chk("R4 write acks", 32'(nk), 0);
      wait_prog();
      set_addr_rd(VEC[v][15:8], nk);
      rx_byte(1'b0, rd);
      bus_stop();
      chk("R2 random read acks", 32'(nk), 0);
      chk("R8 readback", 32'(rd), 32'(VEC[v][7:0]));
    end

    // R9 + R8 wrap: last read was 0xFF, pointer now 0x00
    bus_start(); tx_byte(CTL_R, a); rx_byte(1'b0, rd); bus_stop();
    chk("R9 current read after wrap", 32'(rd), 32'h5A);

    // R8 sequential read and wrap 255 -> 0
    set_addr_rd(8'hFF, nk);
    rx_byte(1'b1, rd); rx_byte(1'b0, rd2); bus_stop();
    chk("R8 seq byte at FF", 32'(rd), 32'hAB);
    chk("R8 seq wrap to 00", 32'(rd2), 32'h5A);

    // R9 current read after read at 0x10
    set_addr_rd(8'h10, nk); rx_byte(1'b0, rd); bus_stop();
    bus_start(); tx_byte(CTL_R, a); rx_byte(1'b0, rd); bus_stop();
    chk("R9 current read increments", 32'(rd), 32'h3E);

    // R3 mismatched select bits: no ack, then ignored
    bus_start();
    tx_byte(8'hA2, a);
    chk("R3 mismatch control nack", 32'(a), 0);
    tx_byte(8'h00, a);
    chk("R3 ignored until Start", 32'(a), 0);
    bus_stop();

    // R5 overflow page write: 20 bytes at 0x40, then R7 busy nack
    write_seq(8'h40, 20, 8'h20, nk);
    chk("R4 page write acks", 32'(nk), 0);
    bus_start(); tx_byte(CTL_W, a); bus_stop();
    chk("R7 control nack while programming", 32'(a), 0);
    wait_prog();
    set_addr_rd(8'h40, nk);
    for (int o = 0; o < 16; o++) begin
      rx_byte(o != 15, rd);
      chk("R5 page overflow keeps last 16", 32'(rd), 32'(8'h20 + 8'((o < 4) ? o + 16 : o)));
    end
    bus_stop();

    // R9 pointer after write: word address 0x40 then 20 bytes -> low nibble 4
    write_seq(8'h40, 20, 8'h20, nk);
    wait_prog();
    bus_start(); tx_byte(CTL_R, a); rx_byte(1'b0, rd); bus_stop();
    chk("R9 pointer after page write", 32'(rd), 32'h24);

    // R5 wrap within page: 3 bytes from 0x8E land at 8E, 8F, 80
    write_seq(8'h8E, 3, 8'h61, nk);
    wait_prog();
    set_addr_rd(8'h80, nk); rx_byte(1'b0, rd); bus_stop();
    chk("R5 page wrap to offset 0", 32'(rd), 32'h63);
    set_addr_rd(8'h7F, nk); rx_byte(1'b0, rd); bus_stop();
    chk("R5 neighbour page untouched", 32'(rd), 32'h81);

    // R6 Stop after address only starts no programming
    write_seq(8'h40, 0, 8'h00, nk);
    bus_start(); tx_byte(CTL_W, a); bus_stop();
    chk("R6 no programming without data", 32'(a), 1);
    set_addr_rd(8'h40, nk); rx_byte(1'b0, rd); bus_stop();
    chk("R6 data unchanged", 32'(rd), 32'h30);

    // R10 host nack: slave released for further clocks
    set_addr_rd(8'h10, nk); rx_byte(1'b0, rd);
    held = 0;
    for (int p = 0; p < 9; p++) begin
      wq(); scl = 1'b1; repeat (Q / 2) @(negedge clk);
      if (!sda_line) held++;
      repeat (Q - Q / 2) @(negedge clk); scl = 1'b0;
    end
    bus_stop();
    chk("R10 released after host nack", 32'(held), 0);

    repeat (20) @(negedge clk);
    chk("R11 oe steady while SCL high", 32'(r11_viol), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule